// File: doc/BRIEF.md
# Row Scan Shift Register Sequencer

This block picks which row of an LED matrix is lit. It does this by driving the serial data line and the shift clock of an external shift register. The outputs of that register switch the row transistors, and a low output turns its row on. A column driver reports when it has finished a row. The sequencer then shifts the register by one position and asks the column driver to start the next row. Once per frame, when the row index wraps back to zero, a single zero is fed into the serial line. This zero walks down the register one row per shift. At the same point the block raises a frame-boundary flag and honours a pending display buffer swap.

The external register has its shift clock and its storage clock tied to one wire. Its visible outputs therefore show the shifted contents one clock late. The one-row offset this causes is accepted, and clearing the register takes one pulse more than the row count. After reset, and again on a suspend request, the block shifts in ones until every row is off. During a suspend it forces the columns off. After the flush it holds an acknowledge until the request is withdrawn, and scanning then resumes at row 0.

Top module: `row_scan_seq`

## Requirements
- R1: While reset is active, `sr_data_o` is 1, `sr_clk_o` is 0, `cols_off_o` is 1, and `row_start_o` and `suspend_ack_o` are 0. After reset the block issues ROWS+1 shift pulses, all with data 1, which leaves every visible row output at 1. It then issues `row_start_o` with `row_idx_o` = 0.
- R2: Each shift pulse has three parts: one setup cycle with the clock low, exactly one cycle with the clock high, and then one cycle with the clock low. `sr_data_o` never changes between the setup cycle and the end of the high cycle.
- R3: A `row_done_i` that arrives while the block waits on a row produces exactly one shift pulse. After that pulse, `row_start_o` is a one-cycle pulse carrying the next row index, which wraps from ROWS-1 to 0.
- R4: The data bit for a shift pulse is 0 only when the row index wraps from ROWS-1 to 0. For every other shift pulse, and for every flush pulse, the bit is 1. Outside a pulse, `sr_data_o` rests at 1.
- R5: `frame_o` is a one-cycle pulse. It is raised in the last low cycle of the wrap pulse, and never at any other time.
- R6: `swap_o` is raised together with `frame_o` exactly when `swap_req_i` is 1 in that cycle. `swap_o` is never raised at any other time.
- R7: `row_done_i` has no effect unless the block is waiting on a row. This includes the reset flush, a shift pulse already in progress, and a suspend. Such a `row_done_i` produces no extra pulse and no extra `row_start_o`.
- R8: If `suspend_req_i` is 1 when a row's shift pulse completes, no `row_start_o` follows. Instead the block sets `cols_off_o` to 1 and issues ROWS+1 pulses with data 1, which turns every visible row off. It then holds `suspend_ack_o` at 1 with the clock low and the data high. This applies even when that pulse is the wrap pulse, and the frame flag is still raised in that case.
- R9: After `suspend_req_i` returns to 0, `suspend_ack_o` and `cols_off_o` drop on the next cycle. That same cycle carries `row_start_o` with index 0, and no flush pulses come before it.
- R10: When the external register is modelled with shift and storage on one clock, at most one visible row output is low at any time after the reset flush. During scanning, exactly one visible row output is low one pulse after a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| row_done_i | input | 1 | One-cycle pulse from the column driver: the current row has finished |
| suspend_req_i | input | 1 | Level: finish the current row, then blank and halt |
| swap_req_i | input | 1 | Level: a display buffer swap is pending |
| row_start_o | output | 1 | One-cycle pulse telling the column driver to start a row |
| row_idx_o | output | IDX_W | Row index that goes with `row_start_o` |
| cols_off_o | output | 1 | Forces all columns off during a flush or a halt |
| suspend_ack_o | output | 1 | The suspend flush is complete and all rows are off |
| frame_o | output | 1 | One-cycle pulse at the frame boundary |
| swap_o | output | 1 | One-cycle pulse: swap the buffers now |
| sr_clk_o | output | 1 | Shift clock (also the storage clock) of the external row register |
| sr_data_o | output | 1 | Serial data to the external row register |

## Verification
The frame boundary and the start of a suspend flush can land on the same pulse completion: the wrap pulse finishes with `suspend_req_i` already high. The bench provokes this by raising the suspend request in the same cycle as the `row_done_i` of the last row. A scoreboard then requires this exact order: the zero-data pulse, the frame flag carrying the swap value, then ROWS+1 flush pulses with data 1, with no row start anywhere in the sequence. A model of the external register checks that the injected zero was flushed and that every row is off before the acknowledge appears.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [2:0] {
    SEQ_FLUSH,
    SEQ_START,
    SEQ_WAIT,
    SEQ_SHIFT,
    SEQ_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW
  } pulse_phase_e;

endpackage

// File: rtl/row_scan_pulse_gen.sv
module row_scan_pulse_gen
  import row_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic bit_i,
  output logic idle_o,
  output logic done_o,
  output logic sr_clk_o,
  output logic sr_data_o
);

  pulse_phase_e phase_q;
  logic         clk_q;
  logic         data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      clk_q   <= 1'b0;
      data_q  <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (go_i) begin
            phase_q <= PH_SETUP;
            data_q  <= bit_i;
          end
        end
        PH_SETUP: begin
          phase_q <= PH_HIGH;
          clk_q   <= 1'b1;
        end
        PH_HIGH: begin
          phase_q <= PH_LOW;
          clk_q   <= 1'b0;
        end
        PH_LOW: begin
          phase_q <= PH_IDLE;
          data_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o    = (phase_q == PH_IDLE);
  assign done_o    = (phase_q == PH_LOW);
  assign sr_clk_o  = clk_q;
  assign sr_data_o = data_q;

endmodule

// File: rtl/row_scan_counter.sv
module row_scan_counter #(
  parameter  int LIMIT = 8,
  localparam int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr_i) begin
      count_q <= '0;
    end else if (inc_i) begin
      count_q <= (count_q == W'(LIMIT - 1)) ? '0 : count_q + 1'b1;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/row_scan_seq.sv
module row_scan_seq
  import row_scan_pkg::*;
#(
  parameter  int ROWS  = 8,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_done_i,
  input  logic             suspend_req_i,
  input  logic             swap_req_i,
  output logic             row_start_o,
  output logic [IDX_W-1:0] row_idx_o,
  output logic             cols_off_o,
  output logic             suspend_ack_o,
  output logic             frame_o,
  output logic             swap_o,
  output logic             sr_clk_o,
  output logic             sr_data_o
);

  localparam int FLUSH_N = ROWS + 1;
  localparam int FL_W    = $clog2(FLUSH_N);

  seq_state_e       state_q;
  logic             susp_flush_q;
  logic             wrap_q;

  logic             gen_go, gen_bit, gen_idle, gen_done;
  logic [IDX_W-1:0] row_cnt;
  logic [FL_W-1:0]  flush_cnt;
  logic             row_last, flush_last;
  logic             row_accept, flush_step, resume;

  assign row_last   = (row_cnt == IDX_W'(ROWS - 1));
  assign flush_last = (flush_cnt == FL_W'(FLUSH_N - 1));
  assign row_accept = (state_q == SEQ_WAIT) && row_done_i;
  assign flush_step = (state_q == SEQ_FLUSH) && gen_done;
  assign resume     = (state_q == SEQ_HALT) && !suspend_req_i;

  assign gen_go  = ((state_q == SEQ_FLUSH) && gen_idle) || row_accept;
  assign gen_bit = (state_q == SEQ_FLUSH) ? 1'b1 : !row_last;

  row_scan_pulse_gen pulse_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (gen_go),
    .bit_i    (gen_bit),
    .idle_o   (gen_idle),
    .done_o   (gen_done),
    .sr_clk_o (sr_clk_o),
    .sr_data_o(sr_data_o)
  );

  row_scan_counter #(.LIMIT(ROWS)) row_ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (row_accept),
    .clr_i  (resume),
    .count_o(row_cnt)
  );

  row_scan_counter #(.LIMIT(FLUSH_N)) flush_ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (flush_step),
    .clr_i  (1'b0),
    .count_o(flush_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_FLUSH;
      susp_flush_q <= 1'b0;
      wrap_q       <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_FLUSH: begin
          if (flush_step && flush_last) begin
            state_q <= (susp_flush_q || suspend_req_i) ? SEQ_HALT : SEQ_START;
          end
        end
        SEQ_START: state_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (row_done_i) begin
            state_q <= SEQ_SHIFT;
            wrap_q  <= row_last;
          end
        end
        SEQ_SHIFT: begin
          if (gen_done) begin
            if (suspend_req_i) begin
              state_q      <= SEQ_FLUSH;
              susp_flush_q <= 1'b1;
            end else begin
              state_q <= SEQ_START;
            end
          end
        end
        SEQ_HALT: begin
          if (!suspend_req_i) begin
            state_q      <= SEQ_START;
            susp_flush_q <= 1'b0;
          end
        end
        default: state_q <= SEQ_FLUSH;
      endcase
    end
  end

  assign row_start_o   = (state_q == SEQ_START);
  assign row_idx_o     = row_cnt;
  assign cols_off_o    = (state_q == SEQ_FLUSH) || (state_q == SEQ_HALT);
  assign suspend_ack_o = (state_q == SEQ_HALT);
  assign frame_o       = (state_q == SEQ_SHIFT) && gen_done && wrap_q;
  assign swap_o        = frame_o && swap_req_i;

endmodule

// File: rtl/row_scan_seq_chk.sv
module row_scan_seq_chk #(
  parameter  int ROWS  = 8,
  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             suspend_req_i,
  input logic             swap_req_i,
  input logic             row_start_o,
  input logic [IDX_W-1:0] row_idx_o,
  input logic             cols_off_o,
  input logic             suspend_ack_o,
  input logic             frame_o,
  input logic             swap_o,
  input logic             sr_clk_o,
  input logic             sr_data_o
);

  // R2
  clk_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clk_o |=> !sr_clk_o);

  // R2
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_clk_o) |-> $stable(sr_data_o));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clk_o |=> $stable(sr_data_o));

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_start_o |=> !row_start_o);

  // R3
  start_idx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_start_o |=> $stable(row_idx_o));

  // R5
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);

  // R5
  frame_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> (!sr_clk_o && !sr_data_o));

  // R6
  swap_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> (frame_o && swap_req_i));

  // R8
  no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cols_off_o |-> !row_start_o);

  // R8
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_ack_o |-> (!sr_clk_o && sr_data_o && cols_off_o));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_ack_o && !suspend_req_i) |=> (!suspend_ack_o && row_start_o && row_idx_o == '0));

endmodule

bind row_scan_seq row_scan_seq_chk #(.ROWS(ROWS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .suspend_req_i(suspend_req_i),
  .swap_req_i   (swap_req_i),
  .row_start_o  (row_start_o),
  .row_idx_o    (row_idx_o),
  .cols_off_o   (cols_off_o),
  .suspend_ack_o(suspend_ack_o),
  .frame_o      (frame_o),
  .swap_o       (swap_o),
  .sr_clk_o     (sr_clk_o),
  .sr_data_o    (sr_data_o)
);

// File: tb/row_scan_seq_tb_top.sv
`timescale 1ns/1ps
module row_scan_seq_tb_top;

  localparam int ROWS = 4;
  localparam int IW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_done = 1'b0, suspend_req = 1'b0, swap_req = 1'b0;
  logic row_start, cols_off, suspend_ack, frame, swap, sr_clk, sr_data;
  logic [IW-1:0] row_idx;

  always #2 clk = ~clk;

  row_scan_seq #(.ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_done_i(row_done), .suspend_req_i(suspend_req),
    .swap_req_i(swap_req), .row_start_o(row_start), .row_idx_o(row_idx),
    .cols_off_o(cols_off), .suspend_ack_o(suspend_ack), .frame_o(frame),
    .swap_o(swap), .sr_clk_o(sr_clk), .sr_data_o(sr_data)
  );

  typedef enum logic [1:0] {EV_PULSE, EV_FRAME, EV_START} ev_kind_e;
  typedef struct packed { ev_kind_e k; logic [7:0] v; } ev_t;

  ev_t expq[$];
  int compared = 0, mismatched = 0;
  int model_row = 0;
  logic prev_clk = 1'b0;
  logic [ROWS-1:0] shreg = '0, vis = '0;
  bit armed = 0, saw_one_zero = 0, done_flag = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic void push(ev_kind_e k, int v);
    ev_t e;
    e.k = k; e.v = 8'(v);
    expq.push_back(e);
  endfunction

  function automatic void check_ev(ev_kind_e k, int v);
    ev_t e;
    string tag;
    tag = (k == EV_PULSE) ? "R4 pulse bit" : (k == EV_FRAME) ? "R5/R6 frame swap" : "R3 start idx";
    if (expq.size() == 0) begin
      chk(0, {tag, " unexpected event kind"}, int'(k), -1);
      return;
    end
    e = expq.pop_front();
    chk(e.k == k, {tag, " event kind"}, int'(k), int'(e.k));
    chk(int'(e.v) == v, {tag, " value"}, v, int'(e.v));
  endfunction

  // Monitor: watches ports, models the external register, pops the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_clk) chk(!sr_clk, "R2 clock high longer than one cycle", int'(sr_clk), 0);
      if (sr_clk && !prev_clk) begin
        vis   = shreg;
        shreg = {shreg[ROWS-2:0], sr_data};
        check_ev(EV_PULSE, int'(sr_data));
        if (armed) begin
          chk($countones(~vis) <= 1, "R10 more than one visible row low", $countones(~vis), 1);
          if ($countones(~vis) == 1) saw_one_zero = 1;
        end
      end
      if (frame) check_ev(EV_FRAME, int'(swap));
      if (row_start) begin
        check_ev(EV_START, int'(row_idx));
        chk(!cols_off, "R3 columns off at row start", int'(cols_off), 0);
      end
      prev_clk = sr_clk;
    end
  end

  task automatic wait_start();
    do @(negedge clk); while (!row_start);
  endtask

  task automatic wait_ack();
    do @(negedge clk); while (!suspend_ack);
  endtask

  // Driver: push the expected results of one row completion, then drive it
  task automatic finish_row(bit susp, bit dup);
    bit wrap;
    int nxt;
    wrap = (model_row == ROWS - 1);
    nxt  = wrap ? 0 : model_row + 1;
    push(EV_PULSE, wrap ? 0 : 1);
    if (wrap) push(EV_FRAME, int'(swap_req));
    if (susp) for (int i = 0; i < ROWS + 1; i++) push(EV_PULSE, 1);
    else push(EV_START, nxt);
    model_row = nxt;
    repeat (3) @(negedge clk);
    row_done = 1'b1;
    if (susp) suspend_req = 1'b1;
    @(negedge clk);
    row_done = 1'b0;
    if (dup) begin
      // R7: second report while the shift pulse is under way
      @(negedge clk);
      row_done = 1'b1;
      @(negedge clk);
      row_done = 1'b0;
    end
    if (susp) wait_ack();
    else wait_start();
  endtask

  task automatic release_suspend();
    push(EV_START, 0);
    model_row = 0;
    suspend_req = 1'b0;
    @(negedge clk);
    chk(!suspend_ack, "R9 ack still high after release", int'(suspend_ack), 0);
    chk(!cols_off, "R9 columns still off after release", int'(cols_off), 0);
    chk(row_start && row_idx == '0, "R9 restart at row 0", int'(row_start), 1);
  endtask

  task automatic check_halted(string tag);
    chk(suspend_ack && cols_off, {tag, " R8 ack with columns off"}, int'(suspend_ack), 1);
    chk(!sr_clk && sr_data, {tag, " R8 quiet register lines"}, int'(sr_data), 1);
    chk(vis == '1, {tag, " R8 all visible rows off"}, int'(vis), (1 << ROWS) - 1);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, {tag, " R8 no further events while halted"}, expq.size(), 0);
    chk(suspend_ack, {tag, " R8 ack held"}, int'(suspend_ack), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(sr_data == 1'b1, "R1 reset data", int'(sr_data), 1);
    chk(sr_clk == 1'b0, "R1 reset clock", int'(sr_clk), 0);
    chk(cols_off == 1'b1, "R1 reset columns off", int'(cols_off), 1);
    chk(!row_start && !suspend_ack, "R1 reset start/ack", int'(row_start), 0);
    for (int i = 0; i < ROWS + 1; i++) push(EV_PULSE, 1);
    push(EV_START, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    row_done = 1'b1;            // R7: ignored during the reset flush
    @(negedge clk);
    row_done = 1'b0;
    wait_start();
    armed = 1;
    chk(vis == '1, "R1 all rows off after reset flush", int'(vis), (1 << ROWS) - 1);

    for (int i = 0; i < 5; i++) finish_row(0, i == 1);
    swap_req = 1'b1;
    while (model_row != 0) finish_row(0, 0);
    swap_req = 1'b0;
    finish_row(0, 0);

    // Suspend in the middle of a frame
    suspend_req = 1'b1;
    finish_row(1, 0);
    check_halted("mid-frame");
    release_suspend();

    // Suspend on the wrap pulse (frame flag and flush coincide)
    swap_req = 1'b1;
    while (model_row != ROWS - 1) finish_row(0, 0);
    finish_row(1, 0);
    swap_req = 1'b0;
    check_halted("wrap");
    release_suspend();

    saw_one_zero = 0;
    for (int i = 0; i < ROWS + 2; i++) finish_row(0, 0);
    chk(saw_one_zero, "R10 walking zero visible", int'(saw_one_zero), 1);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_flag) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule